// File: doc/BRIEF.md
# Mode-Select Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit of parameterised width (4 bits by default, also built at 16). It takes two operands, a mode bit, a two-bit function select and a carry input. From these it produces a result, a carry flag and a zero flag. Operands and results are two's complement values.

In logic mode it applies one of four bitwise operations. In arithmetic mode every function comes from a single ripple adder made of full-adder bit slices. The select code decides whether the first operand is inverted and whether the second operand is passed, inverted or replaced by zero. The carry input supplies the +1 term, so one adder covers transfer, increment, add, add with carry, the one's-complement forms and both subtraction orders. A 2:1 multiplexer steered by the mode bit picks the final result. The flags are held at zero in logic mode.

Top module: `mode_alu`

## Requirements
- R1: With modeArith=0, sel picks a bitwise operation on opA and opB: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 XNOR.
- R2: With modeArith=0, carryIn has no effect on result, carryOut or zeroFlag.
- R3: With modeArith=0, carryOut and zeroFlag are both 0.
- R4: With modeArith=1 and sel=2'b00, result is opA + carryIn modulo 2^WIDTH (transfer or increment).
- R5: With modeArith=1 and sel=2'b01, result is opA + opB + carryIn modulo 2^WIDTH.
- R6: With modeArith=1 and sel=2'b10, result is opA + ~opB + carryIn modulo 2^WIDTH (so carryIn=1 gives opA - opB).
- R7: With modeArith=1 and sel=2'b11, result is ~opA + opB + carryIn modulo 2^WIDTH (so carryIn=1 gives opB - opA).
- R8: With modeArith=1, carryOut is bit WIDTH of the unsigned (WIDTH+1)-bit sum of the two adder operands and carryIn, which is the carry out of the most significant slice.
- R9: With modeArith=1, zeroFlag is 1 exactly when every bit of result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| modeArith | input | 1 | 0 selects logic mode, 1 selects arithmetic mode |
| sel | input | 2 | Function select within the mode |
| carryIn | input | 1 | Carry into the least significant slice (arithmetic only) |
| result | output | WIDTH | Function result |
| carryOut | output | 1 | Carry out of the top slice, 0 in logic mode |
| zeroFlag | output | 1 | Result-is-zero flag, 0 in logic mode |

## Verification
The checker's assertions are immediate and are evaluated whenever the combinational ports change. They assume that every input is a known 0 or 1 and that all inputs of a case are applied together. The bench changes all inputs in one step after a rising clock edge and compares the outputs at the following falling edge, so no half-applied vector is judged. The 4-bit instance receives every combination of operands, mode, select and carry. The 16-bit instance receives random operands over all control codes, and the stimulus also forces the all-ones, zero and equal-operand corner cases that drive the carry and zero flags.

// File: rtl/mode_alu_pkg.sv
package mode_alu_pkg;

  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_XNOR = 2'b11
  } logicOp_t;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic     arith;    // route adder output and enable flags
    logicOp_t logicOp;  // bitwise function in logic mode
    logic     invA;     // adder X input takes ~A
    logic     passB;    // adder Y input takes B (else zero)
    logic     invB;     // adder Y input takes ~B when passed
  } aluCtrl_t;

endpackage

// File: rtl/mode_alu_ctrl.sv
module mode_alu_ctrl
  import mode_alu_pkg::*;
(
  input  logic       modeArith,
  input  logic [1:0] sel,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl.arith   = modeArith;
    ctrl.logicOp = logicOp_t'(sel);
    ctrl.invA    = 1'b0;
    ctrl.passB   = 1'b1;
    ctrl.invB    = 1'b0;
    unique case (sel)
      2'b00: ctrl.passB = 1'b0;  // A (+cin)
      2'b01: ;                   // A + B (+cin)
      2'b10: ctrl.invB  = 1'b1;  // A + ~B (+cin)
      2'b11: ctrl.invA  = 1'b1;  // ~A + B (+cin)
      default: ;
    endcase
  end

endmodule

// File: rtl/mode_alu_slice.sv
module mode_alu_slice (
  input  logic x,
  input  logic y,
  input  logic cIn,
  output logic s,
  output logic cOut
);

  logic halfSum;

  assign halfSum = x ^ y;
  assign s       = halfSum ^ cIn;
  assign cOut    = (x & y) | (halfSum & cIn);

endmodule

// File: rtl/mode_alu_dp.sv
module mode_alu_dp
  import mode_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  aluCtrl_t         ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             zeroFlag
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] logicRes;
  logic [WIDTH-1:0] addX;
  logic [WIDTH-1:0] addY;
  logic [WIDTH-1:0] sumRes;
  logic [WIDTH:0]   carryChain;

  // Bitwise logic unit
  always_comb begin
    unique case (ctrl.logicOp)
      LOP_AND:  logicRes = opA & opB;
      LOP_OR:   logicRes = opA | opB;
      LOP_XOR:  logicRes = opA ^ opB;
      LOP_XNOR: logicRes = ~(opA ^ opB);
      default:  logicRes = '0;
    endcase
  end

  // Operand conditioning in front of the adder
  assign addX = ctrl.invA ? ~opA : opA;
  assign addY = ctrl.passB ? (ctrl.invB ? ~opB : opB) : '0;

  // Ripple chain of full-adder slices
  assign carryChain[0] = carryIn;
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    mode_alu_slice slice_i (
      .x    (addX[i]),
      .y    (addY[i]),
      .cIn  (carryChain[i]),
      .s    (sumRes[i]),
      .cOut (carryChain[i+1])
    );
  end

  // Output multiplexer and flags
  assign result   = ctrl.arith ? sumRes : logicRes;
  assign carryOut = ctrl.arith & carryChain[MSB+1];
  assign zeroFlag = ctrl.arith & ~(|sumRes);

endmodule

// File: rtl/mode_alu.sv
module mode_alu
  import mode_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             modeArith,
  input  logic [1:0]       sel,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             zeroFlag
);

  aluCtrl_t ctrl;

  mode_alu_ctrl ctrl_i (
    .modeArith (modeArith),
    .sel       (sel),
    .ctrl      (ctrl)
  );

  mode_alu_dp #(.WIDTH(WIDTH)) dp_i (
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .result   (result),
    .carryOut (carryOut),
    .zeroFlag (zeroFlag)
  );

endmodule

// File: rtl/mode_alu_chk.sv
module mode_alu_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             modeArith,
  input logic [1:0]       sel,
  input logic             carryIn,
  input logic [WIDTH-1:0] result,
  input logic             carryOut,
  input logic             zeroFlag
);

  logic [WIDTH:0]   expSum;
  logic [WIDTH-1:0] expLogic;

  always_comb begin
    unique case (sel)
      2'b00: expSum = {1'b0, opA} + {(WIDTH+1){1'b0}} + {{WIDTH{1'b0}}, carryIn};
      2'b01: expSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
      2'b10: expSum = {1'b0, opA} + {1'b0, ~opB} + {{WIDTH{1'b0}}, carryIn};
      default: expSum = {1'b0, ~opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
    endcase
    unique case (sel)
      2'b00: expLogic = opA & opB;
      2'b01: expLogic = opA | opB;
      2'b10: expLogic = opA ^ opB;
      default: expLogic = ~(opA ^ opB);
    endcase
  end

  always_comb begin
    if (!modeArith) begin
      AST_LOGIC_FLAGS_CLEAR: assert (!carryOut && !zeroFlag); // R3
      AST_LOGIC_RESULT: assert (result == expLogic); // R1
    end else begin
      AST_ARITH_SUM: assert ({carryOut, result} == expSum); // R8
      AST_ZERO_FLAG: assert (zeroFlag == (result == '0)); // R9
    end
  end

endmodule

bind mode_alu mode_alu_chk #(.WIDTH(WIDTH)) chk_i (
  .opA       (opA),
  .opB       (opB),
  .modeArith (modeArith),
  .sel       (sel),
  .carryIn   (carryIn),
  .result    (result),
  .carryOut  (carryOut),
  .zeroFlag  (zeroFlag)
);

// File: tb/mode_alu_tb_top.sv
`timescale 1ns/1ps
module mode_alu_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // 4-bit instance
  logic [3:0]  a4, b4, f4;
  logic        m4, c4, cy4, z4;
  logic [1:0]  s4;
  // 16-bit instance
  logic [15:0] a16, b16, f16;
  logic        m16, c16, cy16, z16;
  logic [1:0]  s16;

  mode_alu #(.WIDTH(4)) dut_i (
    .opA(a4), .opB(b4), .modeArith(m4), .sel(s4), .carryIn(c4),
    .result(f4), .carryOut(cy4), .zeroFlag(z4)
  );

  mode_alu #(.WIDTH(16)) dut16_i (
    .opA(a16), .opB(b16), .modeArith(m16), .sel(s16), .carryIn(c16),
    .result(f16), .carryOut(cy16), .zeroFlag(z16)
  );

  // Behavioural reference
  function automatic void refModel(input int w, input longint a, input longint b,
                                   input bit m, input int s, input bit c,
                                   output longint f, output bit cy, output bit z);
    longint mask = (longint'(1) << w) - 1;
    longint x, y, sum;
    if (!m) begin
      case (s)
        0: f = a & b;
        1: f = a | b;
        2: f = a ^ b;
        default: f = ~(a ^ b) & mask;
      endcase
      cy = 1'b0;
      z  = 1'b0;
    end else begin
      x = (s == 3) ? (~a & mask) : a;
      if (s == 0)      y = 0;
      else if (s == 2) y = ~b & mask;
      else             y = b;
      sum = x + y + longint'(c);
      f  = sum & mask;
      cy = ((sum >> w) & 1) != 0;
      z  = (f == 0);
    end
  endfunction

  function automatic string reqOf(input bit m, input int s, input bit c);
    if (!m) return c ? "R2" : "R1";
    case (s)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare4();
    longint ef; bit ecy, ez;
    refModel(4, longint'(a4), longint'(b4), m4, int'(s4), c4, ef, ecy, ez);
    check(reqOf(m4, int'(s4), c4), "result4", longint'(f4), ef);
    check(m4 ? "R8" : "R3", "carry4", longint'(cy4), longint'(ecy));
    check(m4 ? "R9" : "R3", "zero4", longint'(z4), longint'(ez));
  endtask

  task automatic compare16();
    longint ef; bit ecy, ez;
    refModel(16, longint'(a16), longint'(b16), m16, int'(s16), c16, ef, ecy, ez);
    check(reqOf(m16, int'(s16), c16), "result16", longint'(f16), ef);
    check(m16 ? "R8" : "R3", "carry16", longint'(cy16), longint'(ecy));
    check(m16 ? "R9" : "R3", "zero16", longint'(z16), longint'(ez));
  endtask

  task automatic apply16(input logic [15:0] a, input logic [15:0] b,
                         input bit m, input logic [1:0] s, input bit c);
    @(posedge clk);
    a16 = a; b16 = b; m16 = m; s16 = s; c16 = c;
    @(negedge clk);
    compare16();
  endtask

  initial begin
    a4 = '0; b4 = '0; m4 = 1'b0; s4 = 2'b00; c4 = 1'b0;
    a16 = '0; b16 = '0; m16 = 1'b0; s16 = 2'b00; c16 = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Idle state: all-zero inputs, logic AND, flags clear (R1, R3)
    check("R1", "idle result", longint'(f4), 0);
    check("R3", "idle carry", longint'(cy4), 0);
    check("R3", "idle zero", longint'(z4), 0);

    // Exhaustive sweep at 4 bits
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
              @(posedge clk);
              a4 = 4'(a); b4 = 4'(b); m4 = 1'(m); s4 = 2'(s); c4 = 1'(c);
              @(negedge clk);
              compare4();
            end

    // 16-bit corner cases
    apply16(16'hFFFF, 16'h0000, 1'b1, 2'b00, 1'b1); // R4 wrap to zero, carry
    apply16(16'hFFFF, 16'h0001, 1'b1, 2'b01, 1'b0); // R5 carry out
    apply16(16'h1234, 16'h1234, 1'b1, 2'b10, 1'b1); // R6 equal -> zero
    apply16(16'h0005, 16'h0003, 1'b1, 2'b11, 1'b1); // R7 negative result
    apply16(16'hA5A5, 16'hFFFF, 1'b0, 2'b11, 1'b1); // R2 carry ignored
    apply16(16'h0000, 16'h0000, 1'b0, 2'b00, 1'b0); // R3 zero result, flag stays low

    // 16-bit random vectors over all control codes
    for (int i = 0; i < 3000; i++)
      apply16(16'($urandom), 16'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule